// File: doc/BRIEF.md
# Half-Cycle Corrected Clock Divider

This block derives a slower clock from a fast system clock by a run-time integer ratio N. The ratio is taken from an input when the divider starts. A counter runs over N system clocks. The output is high while the count is below the compare value (N+1)/2 and low for the rest of the period. An even N then gives an exact 50% duty cycle.

An odd N would leave the high phase one system clock longer than the low phase. For example, N = 5 gives 3 clocks high against 2 clocks low, a 60/40 split. To fix this, the block samples the high phase again on the falling system-clock edge and ANDs that copy into the output. This moves the rising edge half a system clock later, so both phases last N half-clocks. A complemented copy of the output can be built in, for boards that want the clock on the opposite pin of a pair.

A three-state machine controls the sequence:
- State OFF: the output is low and the counter is cleared.
- Transition *start*: OFF goes to HIGH when enable is set and the ratio is at least 2. The ratio and its odd flag are latched at this point.
- Transition *split*: HIGH goes to LOW once the count reaches (N+1)/2 - 1.
- Transition *wrap*: LOW goes back to HIGH with the count at 0 once the count reaches N-1.
- Transition *stop*: every state goes to OFF when enable is low.

Top module: `clkdiv_halfodd`

## Requirements
- R1: While reset is asserted, and from the first system clock edge after enable is sampled low, `clk_out` is 0.
- R2: A ratio value of 0 or 1 keeps the divider in OFF even with enable high, so `clk_out` stays 0.
- R3: While enabled with a latched ratio N of at least 2, `clk_out` has a period of exactly N system clocks (2N half-clocks), and the internal count never reaches N.
- R4: For even N, `clk_out` is high for N/2 system clocks and low for N/2 system clocks.
- R5: For odd N, `clk_out` is high for N half-clocks and low for N half-clocks. The rising edge falls on a falling edge of `clk`.
- R6: On the rising clock edge that first samples enable high (with N at least 2), `clk_out` goes high at once if N is even, and half a clock later if N is odd.
- R7: Changing `ratio` while running has no effect on the period. The value latched at start stays in force until the next stop/start.
- R8: With `INV_EN` = 1, `clk_out_n` is always the complement of `clk_out`, including during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock. Both edges are used. |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Run enable. Low stops the divider and clears the counter. |
| ratio | input | RATIO_W | Divide ratio N, latched at start |
| clk_out | output | 1 | Divided clock |
| clk_out_n | output | 1 | Complement of `clk_out` (tied 0 when `INV_EN` = 0) |

## Verification
The state-machine properties assume that `en` and `ratio` are synchronous to the rising edge of `clk`. They also assume that a ratio only takes effect at the start transition. The bench therefore changes both inputs at falling edges only. It moves `ratio` while running only to show that the latched value is kept. Pulse widths are measured by sampling `clk_out` shortly after every clock edge, in half-clock units. Each measured high/low pair is compared with what the driver queued for that run.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_HIGH = 2'd1,
        S_LOW  = 2'd2
    } div_state_e;

endpackage

// File: rtl/clkdiv_seq.sv
module clkdiv_seq
    import clkdiv_pkg::*;
#(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               phase_hi,
    output logic               odd_q
);

    localparam int HALF_W = RATIO_W + 1;
    localparam logic [RATIO_W-1:0] MIN_RATIO = RATIO_W'(2);

    div_state_e         state_q, state_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] ratio_q, ratio_d;
    logic [RATIO_W-1:0] half_q, half_d;
    logic               odd_d;
    logic [HALF_W-1:0]  half_calc;
    logic               ratio_ok;
    logic               hit_split;
    logic               hit_wrap;

    assign half_calc = ({1'b0, ratio} + HALF_W'(1)) >> 1;
    assign ratio_ok  = (ratio >= MIN_RATIO);
    assign hit_split = (cnt_q == half_q - RATIO_W'(1));
    assign hit_wrap  = (cnt_q == ratio_q - RATIO_W'(1));

    // next-state and datapath
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        half_d  = half_q;
        odd_d   = odd_q;
        if (!en) begin
            state_d = S_OFF;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                S_OFF: begin
                    cnt_d = '0;
                    if (ratio_ok) begin
                        state_d = S_HIGH;
                        ratio_d = ratio;
                        half_d  = half_calc[RATIO_W-1:0];
                        odd_d   = ratio[0];
                    end
                end
                S_HIGH: begin
                    cnt_d = cnt_q + RATIO_W'(1);
                    if (hit_split) state_d = S_LOW;
                end
                S_LOW: begin
                    if (hit_wrap) begin
                        state_d = S_HIGH;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + RATIO_W'(1);
                    end
                end
                default: begin
                    state_d = S_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            cnt_q   <= '0;
            ratio_q <= MIN_RATIO;
            half_q  <= RATIO_W'(1);
            odd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
            half_q  <= half_d;
            odd_q   <= odd_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            S_HIGH:  phase_hi = 1'b1;
            default: phase_hi = 1'b0;
        endcase
    end

    p_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> state_q == S_OFF);

    p_bad_ratio_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF && ratio < MIN_RATIO) |=> state_q == S_OFF);

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_OFF) |-> (cnt_q < ratio_q));

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == S_LOW && hit_wrap) |=> (state_q == S_HIGH && cnt_q == '0));

    p_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state_q == S_HIGH && hit_split) |=> state_q == S_LOW);

endmodule

// File: rtl/clkdiv_halfcyc.sv
module clkdiv_halfcyc (
    input  logic clk,
    input  logic rst_n,
    input  logic odd,
    input  logic phase_hi,
    output logic div_out
);

    logic neg_q;

    // falling-edge copy of the high phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) neg_q <= 1'b0;
        else        neg_q <= phase_hi;
    end

    // odd ratios: rise waits for the falling-edge copy, fall follows at once
    always_comb begin
        if (odd) div_out = phase_hi & neg_q;
        else     div_out = phase_hi;
    end

endmodule

// File: rtl/clkdiv_halfodd.sv
module clkdiv_halfodd #(
    parameter int RATIO_W = 8,
    parameter bit INV_EN  = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [RATIO_W-1:0] ratio,
    output logic               clk_out,
    output logic               clk_out_n
);

    logic phase_hi;
    logic odd_q;

    clkdiv_seq #(.RATIO_W(RATIO_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .ratio    (ratio),
        .phase_hi (phase_hi),
        .odd_q    (odd_q)
    );

    clkdiv_halfcyc u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .odd      (odd_q),
        .phase_hi (phase_hi),
        .div_out  (clk_out)
    );

    generate
        if (INV_EN) begin : g_inv
            assign clk_out_n = ~clk_out;
        end else begin : g_no_inv
            assign clk_out_n = 1'b0;
        end
    endgenerate

endmodule

// File: tb/tb_clkdiv_halfodd.sv
`timescale 1ns/1ps
module tb_clkdiv_halfodd;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] ratio = '0;
    logic         clk_out;
    logic         clk_out_n;

    clkdiv_halfodd #(.RATIO_W(W), .INV_EN(1'b1)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .ratio     (ratio),
        .clk_out   (clk_out),
        .clk_out_n (clk_out_n)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int exp_hi[$];
    int exp_lo[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: half-clock sampling, pair = high run + following low run
    bit   in_pair = 1'b0;
    int   run = 0;
    int   hi_len = 0;
    logic prev = 1'b0;
    logic smp;
    int   inv_bad = 0;
    int   eh, el;

    always @(clk) begin
        #2;
        smp = clk_out;
        if (clk_out_n !== ~clk_out) inv_bad++;
        if (!en) begin
            in_pair = 1'b0;
            run = 0;
        end else if (smp && !prev) begin
            if (in_pair && exp_hi.size() > 0) begin
                eh = exp_hi.pop_front();
                el = exp_lo.pop_front();
                chk(hi_len == eh, "R3/R4/R5", "high half-clocks", hi_len, eh);
                chk(run == el, "R3/R4/R5", "low half-clocks", run, el);
            end
            in_pair = 1'b1;
            run = 1;
        end else if (!smp && prev) begin
            hi_len = run;
            run = 1;
        end else begin
            run++;
        end
        prev = smp;
    end

    // driver: queue expected pulses and run the divider
    task automatic run_ratio(input int n, input int pulses, input int newn);
        @(negedge clk);
        ratio = W'(n);
        for (int i = 0; i < pulses; i++) begin
            exp_hi.push_back(n);   // N half-clocks high, R4 even / R5 odd
            exp_lo.push_back(n);
        end
        en = 1'b1;
        if (newn > 0) begin
            repeat (3) @(negedge clk);
            ratio = W'(newn);      // R7: must be ignored until restart
        end
        wait (exp_hi.size() == 0);
        repeat (2) @(negedge clk);
        en = 1'b0;
        @(posedge clk);
        #2;
        chk(clk_out == 1'b0, "R1", "output after stop", int'(clk_out), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic start_check(input int n);
        @(negedge clk);
        ratio = W'(n);
        en = 1'b1;
        @(posedge clk);
        #2;
        chk(clk_out == ((n % 2) == 0), "R6", "level just after start edge",
            int'(clk_out), int'((n % 2) == 0));
        @(negedge clk);
        #2;
        chk(clk_out == 1'b1, "R6", "level half clock after start", int'(clk_out), 1);
        repeat (3 * n) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic bad_ratio(input int n);
        int highs;
        highs = 0;
        @(negedge clk);
        ratio = W'(n);
        en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            @(clk);
            #2;
            if (clk_out) highs++;
        end
        chk(highs == 0, "R2", "high samples with small ratio", highs, 0);
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        #10;
        chk(clk_out == 1'b0, "R1", "output in reset", int'(clk_out), 0);
        chk(clk_out_n == 1'b1, "R8", "inverted output in reset", int'(clk_out_n), 1);
        #30;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run_ratio(2, 4, 0);
        run_ratio(3, 4, 0);
        run_ratio(4, 4, 0);
        run_ratio(5, 4, 0);
        run_ratio(7, 3, 0);
        run_ratio(8, 3, 0);
        run_ratio(255, 2, 0);
        run_ratio(4, 5, 7);     // R7
        run_ratio(7, 3, 2);     // R7

        start_check(4);
        start_check(5);
        start_check(2);
        start_check(3);

        bad_ratio(1);
        bad_ratio(0);

        chk(inv_bad == 0, "R8", "complement mismatches", inv_bad, 0);
        finish_run();
    end

endmodule